// File: doc/BRIEF.md
# Time-slotted serial link frame transmitter

This block is the sending side of a time-slotted serial audio and control link. It runs on the link's bit clock and builds a continuous stream of fixed-length frames. It drives a frame strobe and one serial data line. Every frame begins with a 16-bit header slot. Twelve 20-bit payload slots follow the header. All bits leave most significant bit first.

The header announces which payload slots carry live data, so streams with different sample rates can share one fixed frame rate. It also carries a two-bit address that selects the target codec. The upstream side presents the twelve payloads, a valid flag for each one and the codec address as parallel inputs. The block captures all of them once per frame, on the edge where the strobe rises. It raises a one-cycle done pulse on that same edge, so the upstream side has a full frame period to prepare the next set. All outputs change on the rising clock edge, which suits a receiver that samples on the falling edge.

Top module: `acl_frame_tx`

## Requirements
- R1: While rst_n is low, sync_o, sdata_o and frame_done_o are all low. The first rising clock edge after rst_n rises asserts sync_o and starts a frame.
- R2: A frame lasts 256 clock cycles and frames follow each other with no gap. sync_o is high for the first 16 cycles of each frame and low for the other 240.
- R3: Frame bit 0 appears on sdata_o one cycle after sync_o rises, and one frame bit follows on each later cycle. The order is the 16 header bits, then slot 1 to slot 12 at 20 bits each, every field most significant bit first.
- R4: Header bit 15, the first bit sent, is 1 exactly when at least one of the twelve captured valid flags is set.
- R5: Header bits 14 down to 3 are the captured valid flags of slots 1 to 12 in that order: slot_valid_i[0] (slot 1) appears in bit 14 and slot_valid_i[11] (slot 12) in bit 3.
- R6: Header bit 2 is always 0. Header bits 1 and 0 are codec_id_i[1:0] as captured.
- R7: Slot n (1 to 12) sends slot_data_i[(n-1)*20 +: 20] most significant bit first when its captured valid flag is 1, and sends twenty zeros when that flag is 0.
- R8: The inputs are captured only on the clock edge where sync_o rises. Changing them on any other cycle has no effect on the frame being sent.
- R9: frame_done_o is high for exactly one cycle per frame. That cycle is the one where sdata_o carries the last bit of slot 12, which is also the cycle where sync_o rises for the next frame. The first strobe after reset is not paired with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid_i | input | 12 | Valid flag per payload slot, bit 0 = slot 1 |
| codec_id_i | input | 2 | Codec address placed in the low header bits |
| slot_data_i | input | 240 | Twelve 20-bit payloads, slot 1 in bits 19:0 |
| sync_o | output | 1 | Frame strobe, high during the header slot |
| sdata_o | output | 1 | Serial frame data, most significant bit first |
| frame_done_o | output | 1 | One-cycle pulse with the last bit of slot 12 |

## Verification
If the slot sequencer slips by even one count, the gap between strobe rises is no longer 256 cycles, and every bit after the slip lands in the wrong position. The reference model catches this within a single frame. A fault in the captured header or payload shows on sdata_o at the exact cycle of the affected bit, so the failing check points to the header field or slot involved. Inputs are scrambled on every cycle in one phase of the run, so any capture outside the frame boundary changes sdata_o within that same frame.

// File: rtl/acl_tx_pkg.sv
package acl_tx_pkg;

    // Default link geometry
    parameter int unsigned DEF_NSLOT  = 12;
    parameter int unsigned DEF_SLOT_W = 20;
    parameter int unsigned DEF_TAG_W  = 16;
    parameter int unsigned DEF_CID_W  = 2;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/acl_tag_build.sv
module acl_tag_build #(
    parameter int unsigned NSLOT = 12,
    parameter int unsigned TAG_W = 16,
    parameter int unsigned CID_W = 2
) (
    input  logic [NSLOT-1:0] valid_i,
    input  logic [CID_W-1:0] cid_i,
    output logic [TAG_W-1:0] tag_o
);

    // Lowest header bit that holds a slot flag
    localparam int unsigned FLAG_LO = TAG_W - 1 - NSLOT;

    for (genvar b = 0; b < TAG_W; b++) begin : g_bit
        if (b == TAG_W - 1) begin : g_glob
            assign tag_o[b] = |valid_i;
        end else if (b >= FLAG_LO) begin : g_flag
            assign tag_o[b] = valid_i[TAG_W - 2 - b];
        end else if (b < CID_W) begin : g_cid
            assign tag_o[b] = cid_i[b];
        end else begin : g_rsvd
            assign tag_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/acl_slot_seq.sv
module acl_slot_seq
    import acl_tx_pkg::*;
#(
    parameter int unsigned NSLOT  = 12,
    parameter int unsigned SLOT_W = 20,
    parameter int unsigned TAG_W  = 16,
    localparam int unsigned SI_W  = $clog2(NSLOT + 1),
    localparam int unsigned BI_W  = $clog2(imax(TAG_W, SLOT_W))
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [SI_W-1:0] slot_o,
    output logic [BI_W-1:0] bit_o,
    output logic            last_o
);

    typedef struct packed {
        logic [SI_W-1:0] slot;
        logic [BI_W-1:0] bidx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.bidx == '0) begin
            if (seq_q.slot == SI_W'(NSLOT)) begin
                seq_d.slot = '0;
                seq_d.bidx = BI_W'(TAG_W - 1);
            end else begin
                seq_d.slot = seq_q.slot + 1'b1;
                seq_d.bidx = BI_W'(SLOT_W - 1);
            end
        end else begin
            seq_d.bidx = seq_q.bidx - 1'b1;
        end
    end

    // Reset parks on the final bit of the last slot so the next edge opens a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.slot <= SI_W'(NSLOT);
            seq_q.bidx <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_o = seq_q.slot;
    assign bit_o  = seq_q.bidx;
    assign last_o = (seq_q.slot == SI_W'(NSLOT)) && (seq_q.bidx == '0);

endmodule

// File: rtl/acl_frame_tx.sv
module acl_frame_tx
    import acl_tx_pkg::*;
#(
    parameter int unsigned NSLOT  = DEF_NSLOT,
    parameter int unsigned SLOT_W = DEF_SLOT_W,
    parameter int unsigned TAG_W  = DEF_TAG_W,
    parameter int unsigned CID_W  = DEF_CID_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLOT-1:0]        slot_valid_i,
    input  logic [CID_W-1:0]        codec_id_i,
    input  logic [NSLOT*SLOT_W-1:0] slot_data_i,
    output logic                    sync_o,
    output logic                    sdata_o,
    output logic                    frame_done_o
);

    localparam int unsigned SI_W = $clog2(NSLOT + 1);
    localparam int unsigned BI_W = $clog2(imax(TAG_W, SLOT_W));
    localparam int unsigned TB_W = $clog2(TAG_W);
    localparam int unsigned SB_W = $clog2(SLOT_W);

    typedef struct packed {
        logic                              sync;
        logic                              sdata;
        logic                              done;
        logic                              primed;
        logic [TAG_W-1:0]                  tag;
        logic [NSLOT-1:0][SLOT_W-1:0]      pay;
    } tx_t;

    tx_t tx_d, tx_q;

    logic [SI_W-1:0]  slot;
    logic [BI_W-1:0]  bidx;
    logic             last;
    logic [TAG_W-1:0] tag_new;
    logic             cur_bit;

    acl_slot_seq #(
        .NSLOT  (NSLOT),
        .SLOT_W (SLOT_W),
        .TAG_W  (TAG_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot),
        .bit_o  (bidx),
        .last_o (last)
    );

    acl_tag_build #(
        .NSLOT (NSLOT),
        .TAG_W (TAG_W),
        .CID_W (CID_W)
    ) u_tag (
        .valid_i (slot_valid_i),
        .cid_i   (codec_id_i),
        .tag_o   (tag_new)
    );

    // Bit selected by the sequencer position, from the captured frame image
    always_comb begin
        cur_bit = 1'b0;
        if (slot == '0) begin
            cur_bit = tx_q.tag[bidx[TB_W-1:0]];
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (slot == SI_W'(s + 1)) begin
                cur_bit = tx_q.pay[s][bidx[SB_W-1:0]];
            end
        end
    end

    always_comb begin
        tx_d       = tx_q;
        tx_d.sdata = cur_bit;
        // Strobe covers the positions that fall inside the header slot
        tx_d.sync  = last || ((slot == '0) && (bidx != '0));
        tx_d.done  = 1'b0;
        if (last) begin
            tx_d.done   = tx_q.primed;
            tx_d.primed = 1'b1;
            tx_d.tag    = tag_new;
            for (int s = 0; s < NSLOT; s++) begin
                tx_d.pay[s] = slot_valid_i[s] ? slot_data_i[s*SLOT_W +: SLOT_W] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sync_o       = tx_q.sync;
    assign sdata_o      = tx_q.sdata;
    assign frame_done_o = tx_q.done;

endmodule

// File: rtl/acl_frame_tx_chk.sv
module acl_frame_tx_chk #(
    parameter int unsigned NSLOT  = 12,
    parameter int unsigned SLOT_W = 20,
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned CID_W  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sync_o,
    input logic sdata_o,
    input logic frame_done_o
);

    localparam int unsigned FRAME_LEN = TAG_W + NSLOT * SLOT_W;
    localparam int unsigned CK_W      = $clog2(FRAME_LEN) + 2;
    localparam int unsigned RSVD_POS  = TAG_W - CID_W;

    logic            sync_p;
    logic            seen_q;
    logic [CK_W-1:0] ck_q;
    logic            rise;

    assign rise = sync_o && !sync_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_p <= 1'b0;
            seen_q <= 1'b0;
            ck_q   <= '0;
        end else begin
            sync_p <= sync_o;
            seen_q <= seen_q | rise;
            if (rise) begin
                ck_q <= CK_W'(1);
            end else if (ck_q != '1) begin
                ck_q <= ck_q + 1'b1;
            end
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            rst_quiet_chk: assert (!sync_o && !sdata_o && !frame_done_o);
        end
    end

    // R2
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !rise) |-> (sync_o == (ck_q < CK_W'(TAG_W))));

    // R2
    frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_q) |-> (ck_q == CK_W'(FRAME_LEN)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R9
    done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> rise);

    if (TAG_W - 1 - NSLOT > CID_W) begin : g_rsvd
        // R6
        tag_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && !rise && ck_q == CK_W'(RSVD_POS)) |-> !sdata_o);
    end

endmodule

bind acl_frame_tx acl_frame_tx_chk #(
    .NSLOT  (NSLOT),
    .SLOT_W (SLOT_W),
    .TAG_W  (TAG_W),
    .CID_W  (CID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_o       (sync_o),
    .sdata_o      (sdata_o),
    .frame_done_o (frame_done_o)
);

// File: tb/sim_acl_frame_tx.sv
module sim_acl_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 12;
    localparam int SW   = 20;
    localparam int FLEN = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   valid = '0;
    logic [1:0]      cid = '0;
    logic [NS*SW-1:0] data = '0;
    logic            sync_o, sdata_o, done_o;

    int vectors = 0;
    int misses  = 0;

    // Reference model state
    int   t = 0;
    bit   q_bits[$];
    int   q_req[$];
    bit   e_sync, e_sdata, e_done;
    int   e_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    acl_frame_tx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_valid_i (valid),
        .codec_id_i   (cid),
        .slot_data_i  (data),
        .sync_o       (sync_o),
        .sdata_o      (sdata_o),
        .frame_done_o (done_o)
    );

    task automatic check(input bit act, input bit exp, input int req, input string what);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL R%0d %s t=%0d actual=%0b expected=%0b", req, what, t, act, exp);
        end
    endtask

    // Frame image from the current inputs: header, then slots 1..12 MSB first
    task automatic push_frame();
        bit hdr[16];
        foreach (hdr[i]) hdr[i] = 1'b0;
        hdr[15] = |valid;                          // R4
        for (int k = 0; k < NS; k++) hdr[14-k] = valid[k];   // R5
        hdr[1] = cid[1];                           // R6
        hdr[0] = cid[0];
        for (int b = 15; b >= 0; b--) begin
            q_bits.push_back(hdr[b]);
            q_req.push_back(b == 15 ? 4 : (b >= 3 ? 5 : 6));
        end
        for (int s = 0; s < NS; s++) begin
            for (int k = SW - 1; k >= 0; k--) begin
                q_bits.push_back(valid[s] ? data[s*SW + k] : 1'b0);  // R7
                q_req.push_back(7);
            end
        end
    endtask

    // Called just after a rising edge; inputs are still those seen at that edge
    task automatic model_step();
        int ph = t % FLEN;
        e_sync = (ph < 16);                   // R2
        e_done = (ph == 0) && (t > 0);        // R9
        if (t == 0) begin
            e_sdata = 1'b0;
            e_req   = 3;
        end else begin
            e_sdata = q_bits.pop_front();     // R3 one bit per edge
            e_req   = q_req.pop_front();
        end
        if (ph == 0) push_frame();            // R8 capture only here
        t++;
    endtask

    task automatic compare();
        check(sync_o, e_sync, 2, "sync");
        check(sdata_o, e_sdata, e_req, "sdata");
        check(done_o, e_done, 9, "frame_done");
    endtask

    task automatic scramble();
        valid = NS'($urandom);
        cid   = 2'($urandom);
        for (int i = 0; i < NS*SW; i++) data[i] = 1'($urandom);
    endtask

    task automatic run(input int n, input bit scr);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
            if (scr) scramble();   // R8 inputs move every cycle
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        // R1 outputs quiet during reset
        check(sync_o, 1'b0, 1, "reset sync");
        check(sdata_o, 1'b0, 1, "reset sdata");
        check(done_o, 1'b0, 1, "reset done");
        repeat (3) begin
            @(negedge clk);
            check(sync_o | sdata_o | done_o, 1'b0, 1, "reset hold");
        end
        t = 0;
        q_bits.delete();
        q_req.delete();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // Pattern: all slots valid, counting payloads
        valid = '1;
        cid   = 2'd2;
        for (int s = 0; s < NS; s++) data[s*SW +: SW] = SW'(20'hA0000 + s * 20'h01357);
        do_reset();                 // R1 first edge after release raises sync
        run(FLEN, 1'b0);
        // Pattern: nothing valid, header carries only the address
        valid = '0;
        cid   = 2'd3;
        data  = '1;                 // R7 must not leak
        run(FLEN, 1'b0);
        // Pattern: alternating slots, all-ones payloads
        valid = 12'h555;
        cid   = 2'd1;
        run(FLEN, 1'b0);
        // Pattern: only slot 12
        valid = 12'h800;
        cid   = 2'd0;
        for (int i = 0; i < NS*SW; i++) data[i] = 1'(i % 3 == 0);
        run(FLEN, 1'b0);
        // Inputs changing every cycle
        run(3 * FLEN, 1'b1);
        // Reset in the middle of a frame, then restart
        run(97, 1'b1);
        do_reset();
        valid = 12'h00F;
        cid   = 2'd2;
        run(2 * FLEN + 5, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule